// File: doc/BRIEF.md
# Integer Micro-op Port Steering

This block sits between integer decode and the per-port schedulers. Each cycle it is offered up to six decoded integer micro-ops. Each micro-op carries a class and an opaque tag. The block places every micro-op it can into one of six per-port scheduler queues. Four of these queues feed arithmetic ports and two feed address ports. The ports are not equal. Branches may only use two of the arithmetic ports. Signed multiply has exactly one home, and so does CRC. Address micro-ops go to one of the two address ports.

The micro-ops of a group are judged in program order. The first one that cannot be placed ends the group, and the block reports how many micro-ops it took. Upstream then re-presents the rest in a later cycle. Ops with restricted placement are seated before plain arithmetic ops, and plain ops then spread across the arithmetic queues by free space. Each queue is a plain FIFO with one pop per cycle, driven by its port's issue strobe. A flush empties every queue at once.

Top module: `int_port_steer`

## Requirements
- R1: Slots are evaluated from slot 0 upward. `accept_cnt` equals the index of the first slot that is not valid or cannot be placed, or 6 if none. Only slots below that index are written into queues.
- R2: Class codes are 0 plain arithmetic, 1 branch, 2 signed multiply, 3 CRC and 4 address. Codes 5 to 7 can never be placed. Port numbers 0 to 3 are the arithmetic ports and 4 to 5 are the address ports.
- R3: Each queue holds 14 entries. Free space is 14 minus the occupancy at the start of the cycle. A micro-op whose eligible queues have no free space left is not placed.
- R4: A branch goes to whichever of ports 0 and 1 has more free space, with a tie going to port 0. At most two branches are placed per group, and a third branch is not placed.
- R5: A signed multiply goes only to port 1.
- R6: A CRC op goes only to port 3.
- R7: An address op goes to whichever of ports 4 and 5 has more free space, with a tie going to port 4.
- R8: Branch, multiply, CRC and address ops are seated first, oldest first, stopping at the first one that fails. After that, each plain op older than that point goes to the arithmetic port with the most remaining free space, with a tie going to the lower port number. Free space counts entries already given out earlier in the same cycle.
- R9: When `issue` is high for a port whose queue is not empty, the oldest entry leaves the queue. An issue to an empty queue does nothing. Occupancy at the next edge is the old occupancy plus pushes minus pops.
- R10: While `flush` is high, `accept_cnt` is 0, and at the next edge every queue is empty. Issue has no effect during that cycle.
- R11: Each queue is first-in first-out. Ops steered to the same port in one group enter in slot order, and `head_tag` shows the oldest entry.
- R12: After reset every occupancy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty all queues and accept nothing this cycle |
| in_valid | input | 6 | Valid bit per slot, slot 0 oldest |
| in_class | input | 18 | 3-bit class per slot, slot s at bits 3s+2:3s |
| in_tag | input | 48 | 8-bit payload per slot |
| issue | input | 6 | Pop request per port |
| accept_cnt | output | 3 | Number of slots taken this cycle |
| slot_port | output | 18 | 3-bit target port per slot, 0 for slots not taken |
| occ | output | 24 | 4-bit occupancy per port |
| head_tag | output | 48 | Oldest payload per port, valid when its occupancy is nonzero |

## Verification
The hardest states to reach from the ports are those where a single restricted queue is full while the others still have room. In those states a young restricted op cuts a group short behind an older plain op that does fit. The stimulus reaches them by withholding issue and feeding groups made of only one restricted class until that queue saturates. It then offers mixed groups whose accepted count is worked out by hand. The three-branch limit, unplaceable class codes and gaps in the valid mask are each exercised right after a flush, so the expected counts follow from empty queues.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    OP_SIMPLE = 3'd0,
    OP_BRANCH = 3'd1,
    OP_MUL    = 3'd2,
    OP_CRC    = 3'd3,
    OP_MEM    = 3'd4
  } op_class_e;
endpackage

// File: rtl/steer_alloc.sv
module steer_alloc
  import steer_pkg::*;
#(
  parameter int SLOTS   = 6,
  parameter int NUM_ALU = 4,
  parameter int NUM_AGU = 2,
  parameter int DEPTH   = 14,
  parameter int MAX_BR  = 2
) (
  input  logic [SLOTS-1:0]                          in_valid,
  input  logic [SLOTS*CLS_W-1:0]                    in_class,
  input  logic [(NUM_ALU+NUM_AGU)*$clog2(DEPTH+1)-1:0] occ,
  input  logic                                      block,
  output logic [$clog2(SLOTS+1)-1:0]                accept_cnt,
  output logic [SLOTS*$clog2(NUM_ALU+NUM_AGU)-1:0]  slot_port,
  output logic [SLOTS-1:0]                          slot_go
);
  localparam int NPORT = NUM_ALU + NUM_AGU;
  localparam int PW    = $clog2(NPORT);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int AW    = $clog2(SLOTS + 1);
  localparam int MUL_PORT = 1;
  localparam int CRC_PORT = NUM_ALU - 1;
  localparam logic [NPORT-1:0] ALU_MASK = NPORT'((1 << NUM_ALU) - 1);
  localparam logic [NPORT-1:0] AGU_MASK = ~ALU_MASK;
  localparam logic [NPORT-1:0] BR_MASK  = NPORT'(3);
  localparam logic [NPORT-1:0] MUL_MASK = NPORT'(1) << MUL_PORT;
  localparam logic [NPORT-1:0] CRC_MASK = NPORT'(1) << CRC_PORT;

  // most free eligible port, lowest index on ties, -1 when none has room
  function automatic int pick_best(input logic [NPORT-1:0][CW-1:0] fr,
                                   input logic [NPORT-1:0] mask);
    logic [CW-1:0] bf;
    int best;
    bf   = '0;
    best = -1;
    for (int p = 0; p < NPORT; p++) begin
      if (mask[p] && fr[p] > bf) begin
        bf   = fr[p];
        best = p;
      end
    end
    return best;
  endfunction

  always_comb begin
    logic [NPORT-1:0][CW-1:0] fr;
    logic [CLS_W-1:0] cls;
    int stop;
    int pick;
    int nbr;
    for (int p = 0; p < NPORT; p++) fr[p] = CW'(DEPTH) - occ[p*CW +: CW];
    slot_port = '0;
    stop = block ? 0 : SLOTS;
    nbr  = 0;
    // pass 1: restricted and address classes, oldest first
    for (int s = 0; s < SLOTS; s++) begin
      cls  = in_class[s*CLS_W +: CLS_W];
      pick = -1;
      if (s < stop) begin
        if (!in_valid[s]) begin
          stop = s;
        end else if (cls != OP_SIMPLE) begin
          case (cls)
            OP_BRANCH: pick = (nbr < MAX_BR) ? pick_best(fr, BR_MASK) : -1;
            OP_MUL:    pick = pick_best(fr, MUL_MASK);
            OP_CRC:    pick = pick_best(fr, CRC_MASK);
            OP_MEM:    pick = pick_best(fr, AGU_MASK);
            default:   pick = -1;
          endcase
          if (pick < 0) begin
            stop = s;
          end else begin
            fr[pick] = fr[pick] - 1'b1;
            slot_port[s*PW +: PW] = PW'(pick);
            if (cls == OP_BRANCH) nbr = nbr + 1;
          end
        end
      end
    end
    // pass 2: plain ops older than the first restricted failure
    for (int s = 0; s < SLOTS; s++) begin
      cls  = in_class[s*CLS_W +: CLS_W];
      pick = -1;
      if (s < stop && cls == OP_SIMPLE) begin
        pick = pick_best(fr, ALU_MASK);
        if (pick < 0) begin
          stop = s;
        end else begin
          fr[pick] = fr[pick] - 1'b1;
          slot_port[s*PW +: PW] = PW'(pick);
        end
      end
    end
    for (int s = 0; s < SLOTS; s++) begin
      slot_go[s] = (s < stop);
      if (s >= stop) slot_port[s*PW +: PW] = '0;
    end
    accept_cnt = AW'(stop);
  end
endmodule

// File: rtl/steer_queue.sv
module steer_queue #(
  parameter int DEPTH = 14,
  parameter int TAG_W = 8,
  parameter int SLOTS = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic [$clog2(SLOTS+1)-1:0]   push_n,
  input  logic [SLOTS*TAG_W-1:0]       push_data,
  input  logic                         pop_req,
  output logic [$clog2(DEPTH+1)-1:0]   occ,
  output logic [TAG_W-1:0]             head,
  output logic                         pop_fire
);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int IW  = $clog2(DEPTH);
  localparam int PCW = $clog2(SLOTS + 1);

  logic [TAG_W-1:0] mem [DEPTH];
  logic [IW-1:0]    head_q, tail_q;
  logic [CW-1:0]    occ_q;

  function automatic logic [IW-1:0] wrap_add(input logic [IW-1:0] b, input int n);
    int t;
    t = int'(b) + n;
    if (t >= DEPTH) t = t - DEPTH;
    return IW'(t);
  endfunction

  assign pop_fire = pop_req && (occ_q != '0) && !clear;
  assign occ      = occ_q;
  assign head     = mem[head_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else if (clear) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      head_q <= pop_fire ? wrap_add(head_q, 1) : head_q;
      tail_q <= wrap_add(tail_q, int'(push_n));
      occ_q  <= occ_q + CW'(push_n) - CW'(pop_fire);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++) begin
      if (!clear && PCW'(i) < push_n)
        mem[wrap_add(tail_q, i)] <= push_data[i*TAG_W +: TAG_W];
    end
  end
endmodule

// File: rtl/int_port_steer.sv
module int_port_steer
  import steer_pkg::*;
#(
  parameter int SLOTS   = 6,
  parameter int NUM_ALU = 4,
  parameter int NUM_AGU = 2,
  parameter int DEPTH   = 14,
  parameter int TAG_W   = 8,
  parameter int MAX_BR  = 2
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          flush,
  input  logic [SLOTS-1:0]                              in_valid,
  input  logic [SLOTS*CLS_W-1:0]                        in_class,
  input  logic [SLOTS*TAG_W-1:0]                        in_tag,
  input  logic [NUM_ALU+NUM_AGU-1:0]                    issue,
  output logic [$clog2(SLOTS+1)-1:0]                    accept_cnt,
  output logic [SLOTS*$clog2(NUM_ALU+NUM_AGU)-1:0]      slot_port,
  output logic [(NUM_ALU+NUM_AGU)*$clog2(DEPTH+1)-1:0]  occ,
  output logic [(NUM_ALU+NUM_AGU)*TAG_W-1:0]            head_tag
);
  localparam int NPORT = NUM_ALU + NUM_AGU;
  localparam int PW    = $clog2(NPORT);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int PCW   = $clog2(SLOTS + 1);

  // named internal events, watched by the bound checker
  logic [SLOTS-1:0]                 slot_go;
  logic [NPORT-1:0][PCW-1:0]        push_n;
  logic [NPORT-1:0][SLOTS*TAG_W-1:0] push_data;
  logic [NPORT-1:0]                 pop_fire;

  steer_alloc #(
    .SLOTS(SLOTS), .NUM_ALU(NUM_ALU), .NUM_AGU(NUM_AGU),
    .DEPTH(DEPTH), .MAX_BR(MAX_BR)
  ) u_alloc (
    .in_valid  (in_valid),
    .in_class  (in_class),
    .occ       (occ),
    .block     (flush),
    .accept_cnt(accept_cnt),
    .slot_port (slot_port),
    .slot_go   (slot_go)
  );

  // gather each port's accepted payloads, oldest slot first
  always_comb begin
    int idx;
    for (int p = 0; p < NPORT; p++) begin
      idx = 0;
      push_data[p] = '0;
      for (int s = 0; s < SLOTS; s++) begin
        if (slot_go[s] && slot_port[s*PW +: PW] == PW'(p)) begin
          push_data[p][idx*TAG_W +: TAG_W] = in_tag[s*TAG_W +: TAG_W];
          idx = idx + 1;
        end
      end
      push_n[p] = PCW'(idx);
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_q
    steer_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .SLOTS(SLOTS)) u_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (flush),
      .push_n   (push_n[p]),
      .push_data(push_data[p]),
      .pop_req  (issue[p]),
      .occ      (occ[p*CW +: CW]),
      .head     (head_tag[p*TAG_W +: TAG_W]),
      .pop_fire (pop_fire[p])
    );
  end
endmodule

// File: rtl/int_port_steer_chk.sv
module int_port_steer_chk
  import steer_pkg::*;
#(
  parameter int SLOTS   = 6,
  parameter int NUM_ALU = 4,
  parameter int NUM_AGU = 2,
  parameter int DEPTH   = 14,
  parameter int MAX_BR  = 2
) (
  input logic                                          clk,
  input logic                                          rst_n,
  input logic                                          flush,
  input logic [SLOTS*CLS_W-1:0]                        in_class,
  input logic [$clog2(SLOTS+1)-1:0]                    accept_cnt,
  input logic [SLOTS*$clog2(NUM_ALU+NUM_AGU)-1:0]      slot_port,
  input logic [(NUM_ALU+NUM_AGU)*$clog2(DEPTH+1)-1:0]  occ,
  input logic [NUM_ALU+NUM_AGU-1:0][$clog2(SLOTS+1)-1:0] push_n,
  input logic [NUM_ALU+NUM_AGU-1:0]                    pop_fire
);
  localparam int NPORT = NUM_ALU + NUM_AGU;
  localparam int PW    = $clog2(NPORT);
  localparam int CW    = $clog2(DEPTH + 1);

  logic bad_br, bad_mul, bad_crc, bad_mem, bad_simple, bad_code;
  int   n_br;

  always_comb begin
    logic [CLS_W-1:0] c;
    int pt;
    bad_br = 1'b0; bad_mul = 1'b0; bad_crc = 1'b0;
    bad_mem = 1'b0; bad_simple = 1'b0; bad_code = 1'b0;
    n_br = 0;
    for (int s = 0; s < SLOTS; s++) begin
      c  = in_class[s*CLS_W +: CLS_W];
      pt = int'(slot_port[s*PW +: PW]);
      if (s < int'(accept_cnt)) begin
        case (c)
          OP_BRANCH: begin n_br = n_br + 1; if (pt > 1) bad_br = 1'b1; end
          OP_MUL:    if (pt != 1) bad_mul = 1'b1;
          OP_CRC:    if (pt != NUM_ALU - 1) bad_crc = 1'b1;
          OP_MEM:    if (pt < NUM_ALU || pt >= NPORT) bad_mem = 1'b1;
          OP_SIMPLE: if (pt >= NUM_ALU) bad_simple = 1'b1;
          default:   bad_code = 1'b1;
        endcase
      end
    end
  end

  p_accept_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(accept_cnt) <= SLOTS);
  p_bad_code_r2: assert property (@(posedge clk) disable iff (!rst_n) !bad_code);
  p_branch_port_r4: assert property (@(posedge clk) disable iff (!rst_n) !bad_br);
  p_branch_limit_r4: assert property (@(posedge clk) disable iff (!rst_n) n_br <= MAX_BR);
  p_mul_port_r5: assert property (@(posedge clk) disable iff (!rst_n) !bad_mul);
  p_crc_port_r6: assert property (@(posedge clk) disable iff (!rst_n) !bad_crc);
  p_mem_port_r7: assert property (@(posedge clk) disable iff (!rst_n) !bad_mem);
  p_simple_port_r8: assert property (@(posedge clk) disable iff (!rst_n) !bad_simple);
  p_flush_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> accept_cnt == '0);
  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> occ == '0);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      occ[p*CW +: CW] <= CW'(DEPTH));
    p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pop_fire[p] |-> occ[p*CW +: CW] != '0);
    p_count_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> occ[p*CW +: CW] ==
        $past(occ[p*CW +: CW]) + $past(CW'(push_n[p])) - $past(CW'(pop_fire[p])));
  end
endmodule

bind int_port_steer int_port_steer_chk #(
  .SLOTS(SLOTS), .NUM_ALU(NUM_ALU), .NUM_AGU(NUM_AGU),
  .DEPTH(DEPTH), .MAX_BR(MAX_BR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .in_class  (in_class),
  .accept_cnt(accept_cnt),
  .slot_port (slot_port),
  .occ       (occ),
  .push_n    (push_n),
  .pop_fire  (pop_fire)
);

// File: tb/int_port_steer_bench.sv
module int_port_steer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 6;
  localparam int NP = 6;
  localparam int DEP = 14;
  localparam int VEC_N = 10;

  // {valid[5:0], class slot5..slot0, issue[5:0]}
  localparam logic [29:0] VEC [VEC_N] = '{
    {6'b111111, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, 6'b000000},
    {6'b111111, {3'd3,3'd2,3'd1,3'd1,3'd4,3'd4}, 6'b000001},
    {6'b111111, {3'd3,3'd0,3'd2,3'd0,3'd1,3'd0}, 6'b110000},
    {6'b111111, {3'd4,3'd4,3'd4,3'd4,3'd4,3'd4}, 6'b000000},
    {6'b111111, {3'd0,3'd0,3'd0,3'd1,3'd1,3'd1}, 6'b111111},
    {6'b111111, {3'd2,3'd2,3'd0,3'd3,3'd3,3'd3}, 6'b000000},
    {6'b000111, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, 6'b001010},
    {6'b111111, {3'd7,3'd0,3'd0,3'd0,3'd0,3'd0}, 6'b000000},
    {6'b111111, {3'd4,3'd4,3'd4,3'd4,3'd4,3'd4}, 6'b110000},
    {6'b111111, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, 6'b001111}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic [5:0]  in_valid = '0;
  logic [17:0] in_class = '0;
  logic [47:0] in_tag = '0;
  logic [5:0]  issue = '0;
  logic [2:0]  accept_cnt;
  logic [17:0] slot_port;
  logic [23:0] occ;
  logic [47:0] head_tag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] tagc = 8'h10;
  int mocc [NP];
  logic [7:0] mq [NP][16];

  always #(CLK_PERIOD/2) clk = ~clk;

  int_port_steer u_int_port_steer (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_class(in_class), .in_tag(in_tag), .issue(issue),
    .accept_cnt(accept_cnt), .slot_port(slot_port), .occ(occ), .head_tag(head_tag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int most_free(input int fr[NP], input int lo, input int hi);
    int w;
    w = -1;
    for (int p = hi; p >= lo; p--)
      if (fr[p] > 0 && (w < 0 || fr[p] >= fr[w])) w = p;
    return w;
  endfunction

  function automatic string req_of(input int c);
    case (c)
      0: return "R8 plain port";
      1: return "R4 branch port";
      2: return "R5 multiply port";
      3: return "R6 crc port";
      default: return "R7 address port";
    endcase
  endfunction

  // one cycle: drive, check steering, clock, check queue state
  task automatic step(input logic [5:0] v, input logic [17:0] c, input logic [5:0] iss,
                      input logic f, input int exp_acc, input string exp_req);
    int fr[NP];
    int prt[NS];
    int lim, nb, w, cl;
    @(negedge clk);
    in_valid = v; in_class = c; issue = iss; flush = f;
    for (int s = 0; s < NS; s++) in_tag[s*8 +: 8] = tagc + 8'(s);
    #1;
    for (int p = 0; p < NP; p++) fr[p] = DEP - mocc[p];
    for (int s = 0; s < NS; s++) prt[s] = 0;
    lim = f ? 0 : NS;
    for (int s = 0; s < NS; s++) if (s < lim && !v[s]) lim = s;
    nb = 0;
    for (int s = 0; s < NS; s++) begin
      cl = int'(c[s*3 +: 3]);
      if (s < lim && cl != 0) begin
        case (cl)
          1: w = (nb == 2) ? -1 : most_free(fr, 0, 1);
          2: w = most_free(fr, 1, 1);
          3: w = most_free(fr, 3, 3);
          4: w = most_free(fr, 4, 5);
          default: w = -1;
        endcase
        if (w < 0) lim = s;
        else begin fr[w]--; prt[s] = w; if (cl == 1) nb++; end
      end
    end
    for (int s = 0; s < NS; s++) begin
      if (s < lim && c[s*3 +: 3] == 3'd0) begin
        w = most_free(fr, 0, 3);
        if (w < 0) lim = s;
        else begin fr[w]--; prt[s] = w; end
      end
    end
    chk(int'(accept_cnt) == lim, f ? "R10 accept during flush" : "R1 accept count",
        int'(accept_cnt), lim);
    if (exp_acc >= 0)
      chk(int'(accept_cnt) == exp_acc, exp_req, int'(accept_cnt), exp_acc);
    for (int s = 0; s < NS; s++)
      if (s < lim)
        chk(int'(slot_port[s*3 +: 3]) == prt[s], req_of(int'(c[s*3 +: 3])),
            int'(slot_port[s*3 +: 3]), prt[s]);
    @(posedge clk);
    #1;
    for (int p = 0; p < NP; p++) begin
      if (f) mocc[p] = 0;
      else if (iss[p] && mocc[p] > 0) begin
        for (int i = 0; i < 15; i++) mq[p][i] = mq[p][i+1];
        mocc[p]--;
      end
    end
    if (!f)
      for (int s = 0; s < lim; s++) begin
        mq[prt[s]][mocc[prt[s]]] = tagc + 8'(s);
        mocc[prt[s]]++;
      end
    tagc = tagc + 8'd6;
    for (int p = 0; p < NP; p++) begin
      chk(int'(occ[p*4 +: 4]) == mocc[p], f ? "R10 occupancy after flush" : "R9 occupancy",
          int'(occ[p*4 +: 4]), mocc[p]);
      if (mocc[p] > 0)
        chk(head_tag[p*8 +: 8] == mq[p][0], "R11 head order",
            int'(head_tag[p*8 +: 8]), int'(mq[p][0]));
    end
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) mocc[p] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int p = 0; p < NP; p++)
      chk(occ[p*4 +: 4] == 4'd0, "R12 reset occupancy", int'(occ[p*4 +: 4]), 0);

    for (int k = 0; k < VEC_N; k++)
      step(VEC[k][29:24], VEC[k][23:6], VEC[k][5:0], 1'b0, -1, "");

    // saturate all queues without issue
    step(6'h3f, '0, 6'h3f, 1'b1, 0, "R10 flush accepts none");
    for (int k = 0; k < 12; k++) step(6'h3f, '0, '0, 1'b0, -1, "");
    step(6'h3f, '0, '0, 1'b0, 0, "R3 full arithmetic queues");
    for (int k = 0; k < 5; k++) step(6'h3f, {6{3'd4}}, '0, 1'b0, -1, "");
    step(6'h3f, {6{3'd4}}, 6'b010000, 1'b0, 0, "R3 full address queues");

    // third branch stops the group
    step(6'h3f, '0, 6'h3f, 1'b1, 0, "R10 flush accepts none");
    step(6'h3f, {3'd2,3'd1,3'd1,3'd1,3'd0,3'd0}, '0, 1'b0, 4, "R4 third branch");

    // fill the multiply port
    step(6'h3f, '0, '0, 1'b1, 0, "R10 flush accepts none");
    step(6'h3f, {6{3'd2}}, '0, 1'b0, 6, "R5 multiply group");
    step(6'h3f, {6{3'd2}}, '0, 1'b0, 6, "R5 multiply group");
    step(6'h3f, {6{3'd2}}, '0, 1'b0, 2, "R5 multiply port full");

    // fill the crc port, then a young crc blocks behind an older plain op
    step(6'h3f, '0, '0, 1'b1, 0, "R10 flush accepts none");
    step(6'h3f, {6{3'd3}}, '0, 1'b0, 6, "R6 crc group");
    step(6'h3f, {6{3'd3}}, '0, 1'b0, 6, "R6 crc group");
    step(6'h3f, {6{3'd3}}, '0, 1'b0, 2, "R6 crc port full");
    step(6'h3f, {3'd0,3'd0,3'd0,3'd0,3'd3,3'd0}, '0, 1'b0, 1, "R8 plain before blocked crc");

    // unplaceable class codes and gaps in valid
    step(6'h3f, '0, '0, 1'b1, 0, "R10 flush accepts none");
    step(6'h3f, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd5}, '0, 1'b0, 0, "R2 unplaceable code");
    step(6'b111011, '0, '0, 1'b0, 2, "R1 valid gap");
    step(6'b000011, {3'd0,3'd0,3'd0,3'd0,3'd4,3'd4}, '0, 1'b0, 2, "R7 address pair");

    // issue to empty queues is ignored
    step(6'h3f, '0, '0, 1'b1, 0, "R10 flush accepts none");
    step(6'h00, '0, 6'h3f, 1'b0, 0, "R9 issue on empty");
    step(6'h3f, {6{3'd4}}, 6'h3f, 1'b0, 6, "R9 push and issue together");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule